// File: doc/BRIEF.md
# Memory Interface Traffic Generator

This block exercises the user side of a double-data-rate memory controller. It writes a known pattern through the controller's command queue and write-data queue, reads the same region back, and checks every returned word. A single `start` pulse runs one pass. At the end the block raises `done`, together with either `pass` or `fail`.

Each memory address names one 64-bit word. The memory moves 64 bits on each clock edge, so every data-queue entry is 128 bits wide and carries two adjacent words.

A burst of `BURST_LEN` words therefore takes `BURST_LEN/2` data-queue entries. Consecutive commands step their address by `BURST_LEN`, so the region is covered without gaps. An override parameter can fix the step at 8 for either burst length. With a burst length of 4 this leaves every other burst-sized region unused.

The data for each beat is computed from the command address and the beat index, so read data is checked without storing any copy of it.

Top module: `mem_traffic_gen`

## Requirements
- R1: During and after reset, until `start` is pulsed, `cmd_push`, `wdata_push`, `rd_pop`, `done`, `pass` and `fail` are all low.
- R2: A command word carries an opcode in bits [35:33] (3'b000 write, 3'b001 read), a zero in bit 32, and a 32-bit word address in bits [31:0].
- R3: `BURST_LEN` is 4 or 8. Each write command is preceded by exactly `BURST_LEN/2` data pushes, all made before the command is pushed. Each read command returns `BURST_LEN/2` beats.
- R4: The first command of each phase uses address 0. Each later command adds a stride: `BURST_LEN`, or 8 when `STRIDE_OVERRIDE8` is 1.
- R5: A beat at address A with beat index B is laid out as follows:
  - bits [127:96] hold A;
  - bits [95:64] hold B;
  - bits [63:32] hold the bitwise inverse of A;
  - bits [31:0] hold A XOR 32'hC3C3_3C3C.
- R6: No push is made while the matching full flag is high. A stalled command or data word keeps its value until it is accepted.
- R7: All `NUM_CMDS` write commands are issued before the first read command. Exactly `NUM_CMDS` read commands follow, over the same addresses in the same order.
- R8: Read data is popped only when the read queue is non-empty and reads are in progress. Returned beats are compared in order. Any mismatch sets `fail`, which stays set.
- R9: `done` rises in the cycle after the last expected beat is popped and then stays high. `pass` is high exactly when `done` is high and `fail` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller user clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins one write/read pass when idle |
| cmd_full | input | 1 | Command queue cannot accept a word |
| cmd_push | output | 1 | Command word is written this cycle |
| cmd_word | output | 36 | Opcode, reserved bit and address |
| wdata_full | input | 1 | Write-data queue cannot accept a beat |
| wdata_push | output | 1 | Write beat is written this cycle |
| wdata | output | 128 | Write beat |
| rd_empty | input | 1 | Read-data queue holds no beat |
| rd_pop | output | 1 | Read beat is consumed this cycle |
| rd_data | input | 128 | Head of the read-data queue (shown ahead) |
| done | output | 1 | Pass finished |
| pass | output | 1 | Finished with no mismatch |
| fail | output | 1 | Sticky mismatch flag |

## Verification
The assertions check three things on every cycle:
- a command or data word waiting on a full queue keeps its value and state;
- every issued address is a multiple of the stride;
- `done` and `fail` never fall once set.

Only the scenarios can show the behaviour that depends on the whole sequence:
- the write-before-read ordering;
- exact data counts per command;
- correct patterns and addresses;
- that a single corrupted memory word is caught.

The bench's responder stores writes in an array and returns them for reads. It runs once without stalls, and once with pseudo-random full and empty stalls on all three queues.

// File: rtl/mem_traffic_gen.sv
module mem_traffic_gen #(
  parameter int BURST_LEN        = 8,
  parameter int STRIDE_OVERRIDE8 = 0,
  parameter int NUM_CMDS         = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         cmd_full,
  output logic         cmd_push,
  output logic [35:0]  cmd_word,
  input  logic         wdata_full,
  output logic         wdata_push,
  output logic [127:0] wdata,
  input  logic         rd_empty,
  output logic         rd_pop,
  input  logic [127:0] rd_data,
  output logic         done,
  output logic         pass,
  output logic         fail
);

  localparam int BEATS = BURST_LEN / 2;
  localparam int STEP  = (STRIDE_OVERRIDE8 != 0) ? 8 : BURST_LEN;
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int CW    = $clog2(NUM_CMDS) + 1;
  localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);
  localparam logic [CW-1:0] LAST_CMD  = CW'(NUM_CMDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_WDATA, S_WCMD, S_RCMD, S_RWAIT, S_DONE} st_t;

  st_t           st;
  logic [31:0]   addr, c_addr;
  logic [BW-1:0] beat, c_beat;
  logic [CW-1:0] n_iss, n_cmp;
  logic          fail_q, done_q;

  function automatic logic [127:0] pattern(input logic [31:0] a, input logic [BW-1:0] b);
    return {a, 32'(b), ~a, a ^ 32'hC3C3_3C3C};
  endfunction

  initial assert_burst_len_R3: assert (BURST_LEN == 4 || BURST_LEN == 8);

  assign wdata_push = (st == S_WDATA) && !wdata_full;
  assign wdata      = pattern(addr, beat);
  assign cmd_push   = (st == S_WCMD || st == S_RCMD) && !cmd_full;
  assign cmd_word   = {(st == S_RCMD) ? 3'b001 : 3'b000, 1'b0, addr};
  assign rd_pop     = (st == S_RCMD || st == S_RWAIT) && !rd_empty;
  assign done       = done_q;
  assign fail       = fail_q;
  assign pass       = done_q && !fail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr   <= '0;
      beat   <= '0;
      n_iss  <= '0;
      c_addr <= '0;
      c_beat <= '0;
      n_cmp  <= '0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st     <= S_WDATA;
          addr   <= '0;
          beat   <= '0;
          n_iss  <= '0;
          c_addr <= '0;
          c_beat <= '0;
          n_cmp  <= '0;
        end
        S_WDATA: if (wdata_push) begin
          if (beat == LAST_BEAT) begin
            beat <= '0;
            st   <= S_WCMD;
          end else begin
            beat <= beat + 1'b1;
          end
        end
        S_WCMD: if (cmd_push) begin
          if (n_iss == LAST_CMD) begin
            addr  <= '0;
            n_iss <= '0;
            st    <= S_RCMD;
          end else begin
            addr  <= addr + 32'(STEP);
            n_iss <= n_iss + 1'b1;
            st    <= S_WDATA;
          end
        end
        S_RCMD: if (cmd_push) begin
          if (n_iss == LAST_CMD) begin
            st <= S_RWAIT;
          end else begin
            addr  <= addr + 32'(STEP);
            n_iss <= n_iss + 1'b1;
          end
        end
        default: ;
      endcase

      if (rd_pop) begin
        if (rd_data != pattern(c_addr, c_beat)) fail_q <= 1'b1;
        if (c_beat == LAST_BEAT) begin
          c_beat <= '0;
          c_addr <= c_addr + 32'(STEP);
          n_cmp  <= n_cmp + 1'b1;
          if (n_cmp == LAST_CMD) begin
            done_q <= 1'b1;
            st     <= S_DONE;
          end
        end else begin
          c_beat <= c_beat + 1'b1;
        end
      end
    end
  end

  assert_cmd_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WCMD || st == S_RCMD) && cmd_full |=> $stable(cmd_word) && $stable(st));

  assert_wdata_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WDATA) && wdata_full |=> $stable(wdata) && (st == S_WDATA));

  assert_addr_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_push |-> (cmd_word[31:0] % 32'(STEP)) == 32'd0);

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> fail);

endmodule

// File: tb/mem_traffic_gen_tb.sv
module mem_traffic_gen_tb;
  localparam int BL    = 4;
  localparam int NUM   = 6;
  localparam int BEATS = BL / 2;
  localparam int STEP  = BL;

  logic clk = 0, rst_n = 0, start = 0;
  logic cmd_full = 0, wdata_full = 0, rd_empty = 1;
  logic [127:0] rd_data = '0;
  logic cmd_push, wdata_push, rd_pop, done, pass, fail;
  logic [35:0] cmd_word;
  logic [127:0] wdata;

  int total = 0, bad = 0;
  int stall_en = 0, corrupt_en = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [127:0] wq[$];
  logic [127:0] rq[$];
  logic [63:0]  mem [0:255];
  int n_wcmd, n_rcmd, n_pops, n_wbeats, done_seen;
  logic [31:0] exp_waddr, exp_raddr;

  always #2 clk = ~clk;

  mem_traffic_gen #(.BURST_LEN(BL), .STRIDE_OVERRIDE8(0), .NUM_CMDS(NUM)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmd_full(cmd_full), .cmd_push(cmd_push), .cmd_word(cmd_word),
    .wdata_full(wdata_full), .wdata_push(wdata_push), .wdata(wdata),
    .rd_empty(rd_empty), .rd_pop(rd_pop), .rd_data(rd_data),
    .done(done), .pass(pass), .fail(fail));

  function automatic logic [127:0] pat(input logic [31:0] a, input int b);
    return {a, 32'(b), ~a, a ^ 32'hC3C3_3C3C};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Responder: records what the DUT commits at the next rising edge
  always @(negedge clk) begin
    if (!rst_n) begin
      wq.delete(); rq.delete();
      n_wcmd = 0; n_rcmd = 0; n_pops = 0; n_wbeats = 0; done_seen = 0;
      exp_waddr = 0; exp_raddr = 0;
    end else begin
      if (done && !done_seen) begin
        done_seen = 1;
        chk(n_pops == NUM * BEATS, "R9 done after last beat", n_pops, NUM * BEATS);
      end
      if (wdata_push) begin
        wq.push_back(wdata);
        n_wbeats++;
      end
      if (cmd_push) begin
        logic [2:0]  op;
        logic [31:0] a;
        op = cmd_word[35:33];
        a  = cmd_word[31:0];
        chk(cmd_word[32] == 1'b0, "R2 reserved bit", cmd_word[32], 0);
        if (op == 3'b000) begin
          chk(n_rcmd == 0, "R7 write after read", n_rcmd, 0);
          chk(a == exp_waddr, "R4 write address", a, exp_waddr);
          chk(wq.size() == BEATS, "R3 beats before write cmd", wq.size(), BEATS);
          for (int b = 0; b < BEATS; b++) begin
            logic [127:0] d;
            d = (wq.size() > 0) ? wq.pop_front() : '0;
            chk(d == pat(a, b), "R5 write pattern", d, pat(a, b));
            mem[8'(a + 32'(2 * b))]     = d[63:0];
            mem[8'(a + 32'(2 * b + 1))] = d[127:64];
          end
          if (corrupt_en != 0 && n_wcmd == 1) mem[8'(a)] = mem[8'(a)] ^ 64'h10;
          n_wcmd++;
          exp_waddr = exp_waddr + STEP;
        end else if (op == 3'b001) begin
          chk(n_wcmd == NUM, "R7 read before writes done", n_wcmd, NUM);
          chk(a == exp_raddr, "R4 read address", a, exp_raddr);
          for (int b = 0; b < BEATS; b++)
            rq.push_back({mem[8'(a + 32'(2 * b + 1))], mem[8'(a + 32'(2 * b))]});
          n_rcmd++;
          exp_raddr = exp_raddr + STEP;
        end else begin
          chk(0, "R2 opcode", op, 0);
        end
      end
      if (rd_pop) begin
        chk(rq.size() > 0, "R8 pop on empty", rq.size(), 1);
        if (rq.size() > 0) void'(rq.pop_front());
        n_pops++;
      end
    end
  end

  // Input driver: changes only just after a rising edge
  always @(posedge clk) begin
    #1;
    lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    cmd_full   = (stall_en != 0) && lfsr[0] && lfsr[3];
    wdata_full = (stall_en != 0) && lfsr[1] && lfsr[5];
    rd_empty   = (rq.size() == 0) || ((stall_en != 0) && lfsr[2] && lfsr[7]);
    rd_data    = (rq.size() > 0) ? rq[0] : '0;
  end

  task automatic do_reset();
    rst_n = 0; start = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!cmd_push && !wdata_push && !rd_pop, "R1 pushes in reset",
        {cmd_push, wdata_push, rd_pop}, 0);
    chk(!done && !pass && !fail, "R1 status in reset", {done, pass, fail}, 0);
    rst_n = 1;
  endtask

  task automatic test_reset();
    do_reset();
    repeat (5) @(negedge clk);
    chk(!cmd_push && !wdata_push && !rd_pop && !done && !pass && !fail,
        "R1 idle without start", {cmd_push, wdata_push, rd_pop, done, pass, fail}, 0);
    chk(n_wbeats == 0, "R1 no data before start", n_wbeats, 0);
  endtask

  task automatic run_pass(input int stall, input int corrupt, input string name);
    int t;
    do_reset();
    stall_en = stall; corrupt_en = corrupt;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    t = 0;
    while (!done && t < 20000) begin
      @(negedge clk); t++;
    end
    chk(done == 1'b1, {"R9 done reached ", name}, done, 1);
    chk(n_wcmd == NUM && n_rcmd == NUM, {"R7 command counts ", name}, {n_wcmd, n_rcmd}, {NUM, NUM});
    chk(n_wbeats == NUM * BEATS, {"R3 write beats ", name}, n_wbeats, NUM * BEATS);
    chk(n_pops == NUM * BEATS, {"R8 read beats ", name}, n_pops, NUM * BEATS);
    chk(fail == (corrupt != 0), {"R8 fail flag ", name}, fail, corrupt != 0);
    chk(pass == (corrupt == 0), {"R9 pass flag ", name}, pass, corrupt == 0);
    repeat (10) @(negedge clk);
    chk(done && fail == (corrupt != 0) && !rd_pop && !cmd_push,
        {"R9 sticky after done ", name}, {done, fail, rd_pop, cmd_push}, {1'b1, corrupt != 0, 2'b00});
    stall_en = 0; corrupt_en = 0;
  endtask

  task automatic test_clean();   run_pass(0, 0, "clean");   endtask
  task automatic test_stalled(); run_pass(1, 0, "stalled"); endtask
  task automatic test_corrupt(); run_pass(0, 1, "corrupt"); endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_reset();
    test_clean();
    test_stalled();
    test_corrupt();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule